// File: doc/BRIEF.md
# Text Mode Character Generator

This block turns text-buffer cells into dots for a monitor. The screen holds 80 columns by 25 rows of character codes. Video timing logic looks up the code for the current cell and presents it with the dot column and the scanline inside that cell. The block returns one pixel bit for each request.

The glyph table covers 128 characters. Each glyph is a 9-row by 7-column dot matrix, and each character has one extra flag. When that flag is set, the glyph drops by two scanlines inside an 11-line cell, so that letters with descenders keep their tails. Each cell is 8 dots wide: 7 glyph columns and one blank spacing column. Codes of 128 and above have no glyph and show as blank. The table contents are computed when the design is elaborated, from a fixed rule that is stated below.

Requests come in on a valid/ready stream and pixels leave on another. An input beat transfers on a rising edge when `in_valid` and `in_ready` are both high. An output beat transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented pixel is held, and `in_ready` falls once both internal stages are full. No beat is lost or duplicated, and beats leave in the order they arrived.

Top module: `text_char_gen`

## Requirements
- R1: With `out_ready` high, an input beat accepted on one rising edge is presented on `out_valid`/`out_pix` after the second rising edge, counting the accepting edge as the first.
- R2: Glyph row r (0..8) of code c (0..127) is the 7-bit value c rotated left by (r mod 7) positions. Glyph column x (0..6) shows bit (6 - x) of that row value, so column 0 is the most significant bit.
- R3: The descender flag is set for codes 0x67, 0x6A, 0x70, 0x71 and 0x79 only.
- R4: For a code without the descender flag, scanlines 0..8 show glyph rows 0..8 and scanlines 9 and 10 are blank.
- R5: For a code with the descender flag, scanlines 2..10 show glyph rows 0..8 and scanlines 0 and 1 are blank.
- R6: Dot column 7 of every cell is blank.
- R7: Codes 128..255 produce a blank pixel for every scanline and column.
- R8: Scanlines 11..15 produce a blank pixel for every code.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pix` does not change on the next edge.
- R10: `in_ready` is low only when both pipeline stages hold a beat and `out_ready` is low. Every accepted beat leaves exactly once, in arrival order.
- R11: During and after reset (`rst_n` low, asynchronous), `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request beat present |
| in_ready | output | 1 | Block can accept a request |
| in_code | input | 8 | Character code from the text buffer |
| in_line | input | 4 | Scanline within the cell, 0..10 |
| in_col | input | 3 | Dot column within the cell, 0..7 |
| out_valid | output | 1 | Pixel beat present |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pix | output | 1 | Pixel bit, 1 = lit |

## Verification
A wrong descender flag or a wrong row offset appears at the ports two edges after the request: whole glyphs shift by two scanlines, and the top or bottom lines light where they should stay dark. A damaged rotation or a wrong column index flips individual dots, so a sweep over every code, scanline and column exposes it. A fault in the stage valid bits appears under back-pressure as a lost beat, a duplicated beat or a pixel that changes while stalled. It is seen on the first stalled cycle or on the first mismatch in the arrival order.

// File: rtl/txtcg_pkg.sv
package txtcg_pkg;
  localparam int CODE_W     = 8;
  localparam int NUM_GLYPHS = 128;
  localparam int GLYPH_ROWS = 9;
  localparam int GLYPH_COLS = 7;
  localparam int DESC_DROP  = 2;
  localparam int CELL_ROWS  = GLYPH_ROWS + DESC_DROP;
  localparam int CELL_COLS  = GLYPH_COLS + 1;
  localparam int LINE_W     = $clog2(CELL_ROWS + 5);
  localparam int COL_W      = $clog2(CELL_COLS);

  typedef logic [GLYPH_COLS-1:0] glyph_row_t;

  // Row pattern: code bits rotated left by (row mod glyph width).
  function automatic glyph_row_t glyph_pattern(input int unsigned code, input int unsigned row);
    glyph_row_t  v;
    int unsigned k;
    v = glyph_row_t'(code);
    k = row % GLYPH_COLS;
    for (int unsigned i = 0; i < k; i++) begin
      v = {v[GLYPH_COLS-2:0], v[GLYPH_COLS-1]};
    end
    return v;
  endfunction

  function automatic logic has_descender(input int unsigned code);
    return (code == 32'h67) || (code == 32'h6A) || (code == 32'h70) ||
           (code == 32'h71) || (code == 32'h79);
  endfunction
endpackage

// File: rtl/txtcg_flow_ctrl.sv
module txtcg_flow_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic out_ready,
  output logic s1_load,
  output logic s2_load,
  output logic s1_valid,
  output logic s2_valid
);
  logic s2_ready;

  assign s2_ready = !s2_valid || out_ready;
  assign in_ready = !s1_valid || s2_ready;
  assign s1_load  = in_valid && in_ready;
  assign s2_load  = s1_valid && s2_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      if (in_ready) s1_valid <= in_valid;
      if (s2_ready) s2_valid <= s1_valid;
    end
  end

  // R10
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (s1_valid && s2_valid && !out_ready));

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !out_ready) |=> s2_valid);
endmodule

// File: rtl/txtcg_row_fetch.sv
module txtcg_row_fetch
  import txtcg_pkg::*;
#(
  parameter int P_CODE_W     = CODE_W,
  parameter int P_NUM_GLYPHS = NUM_GLYPHS,
  parameter int P_GLYPH_ROWS = GLYPH_ROWS,
  parameter int P_GLYPH_COLS = GLYPH_COLS,
  parameter int P_DESC_DROP  = DESC_DROP,
  parameter int P_LINE_W     = LINE_W,
  parameter int P_COL_W      = COL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [P_CODE_W-1:0]     in_code,
  input  logic [P_LINE_W-1:0]     in_line,
  input  logic [P_COL_W-1:0]      in_col,
  output logic [P_GLYPH_COLS-1:0] row_q,
  output logic [P_COL_W-1:0]      col_q
);
  localparam int L_CELL_ROWS = P_GLYPH_ROWS + P_DESC_DROP;
  localparam int TAB_DEPTH   = P_NUM_GLYPHS * P_GLYPH_ROWS;
  localparam int TAB_AW      = $clog2(TAB_DEPTH + 16);
  localparam int GIDX_W      = $clog2(P_NUM_GLYPHS);

  logic [P_GLYPH_COLS-1:0] font_tab [TAB_DEPTH];
  logic                    desc_tab [P_NUM_GLYPHS];

  for (genvar g = 0; g < P_NUM_GLYPHS; g++) begin : g_glyph
    assign desc_tab[g] = has_descender(g);
    for (genvar r = 0; r < P_GLYPH_ROWS; r++) begin : g_row
      assign font_tab[g*P_GLYPH_ROWS + r] = P_GLYPH_COLS'(glyph_pattern(g, r));
    end
  end

  logic                    in_set;
  logic [GIDX_W-1:0]       gidx;
  logic                    drop;
  logic                    hit;
  logic [P_LINE_W-1:0]     grow;
  logic [TAB_AW-1:0]       tab_addr;
  logic [P_GLYPH_COLS-1:0] row_d;

  assign in_set = (in_code < P_CODE_W'(P_NUM_GLYPHS));
  assign gidx   = in_code[GIDX_W-1:0];
  assign drop   = desc_tab[gidx];

  always_comb begin
    hit  = 1'b0;
    grow = '0;
    if (drop) begin
      if (in_line >= P_LINE_W'(P_DESC_DROP) && in_line < P_LINE_W'(L_CELL_ROWS)) begin
        hit  = 1'b1;
        grow = in_line - P_LINE_W'(P_DESC_DROP);
      end
    end else if (in_line < P_LINE_W'(P_GLYPH_ROWS)) begin
      hit  = 1'b1;
      grow = in_line;
    end
    hit = hit && in_set;
  end

  assign tab_addr = TAB_AW'(gidx) * TAB_AW'(P_GLYPH_ROWS) + TAB_AW'(grow);

  always_comb begin
    row_d = '0;
    if (hit) row_d = font_tab[tab_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load) begin
      row_q <= row_d;
      col_q <= in_col;
    end
  end

  // R7
  code_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_code >= P_CODE_W'(P_NUM_GLYPHS)) |=> (row_q == '0));

  // R8
  line_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && in_line >= P_LINE_W'(L_CELL_ROWS)) |=> (row_q == '0));

  // R5
  desc_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && drop && in_line < P_LINE_W'(P_DESC_DROP)) |=> (row_q == '0));

  // R4
  plain_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !drop && in_line >= P_LINE_W'(P_GLYPH_ROWS)) |=> (row_q == '0));
endmodule

// File: rtl/txtcg_pixel_pick.sv
module txtcg_pixel_pick
  import txtcg_pkg::*;
#(
  parameter int P_GLYPH_COLS = GLYPH_COLS,
  parameter int P_COL_W      = COL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [P_GLYPH_COLS-1:0] row_in,
  input  logic [P_COL_W-1:0]      col_in,
  output logic                    pix_q
);
  logic pix_d;

  always_comb begin
    pix_d = 1'b0;
    if (col_in < P_COL_W'(P_GLYPH_COLS)) pix_d = row_in[P_COL_W'(P_GLYPH_COLS-1) - col_in];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pix_q <= 1'b0;
    else if (load) pix_q <= pix_d;
  end

  // R6
  pad_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && col_in >= P_COL_W'(P_GLYPH_COLS)) |=> !pix_q);
endmodule

// File: rtl/text_char_gen.sv
module text_char_gen
  import txtcg_pkg::*;
#(
  parameter int P_CODE_W = CODE_W,
  parameter int P_LINE_W = LINE_W,
  parameter int P_COL_W  = COL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [P_CODE_W-1:0] in_code,
  input  logic [P_LINE_W-1:0] in_line,
  input  logic [P_COL_W-1:0]  in_col,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_pix
);
  logic                  s1_load, s2_load, s1_valid, s2_valid;
  logic [GLYPH_COLS-1:0] row_q;
  logic [P_COL_W-1:0]    col_q;

  txtcg_flow_ctrl u_flow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_ready(out_ready), .s1_load(s1_load), .s2_load(s2_load),
    .s1_valid(s1_valid), .s2_valid(s2_valid)
  );

  txtcg_row_fetch #(
    .P_CODE_W(P_CODE_W), .P_LINE_W(P_LINE_W), .P_COL_W(P_COL_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .load(s1_load), .in_code(in_code),
    .in_line(in_line), .in_col(in_col), .row_q(row_q), .col_q(col_q)
  );

  txtcg_pixel_pick #(
    .P_COL_W(P_COL_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .load(s2_load), .row_in(row_q),
    .col_in(col_q), .pix_q(out_pix)
  );

  assign out_valid = s2_valid;

  // R9
  stall_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_pix));

  // R1
  from_stage1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_valid));
endmodule

// File: tb/text_char_gen_tb.sv
module text_char_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;
  localparam int N_SWEEP = 32768;

  // {req[3:0], code[7:0], line[3:0], col[2:0], expected}
  localparam logic [19:0] VEC [NV] = '{
    {4'd2, 8'h41, 4'd0,  3'd0, 1'b1},  // R2
    {4'd2, 8'h41, 4'd0,  3'd1, 1'b0},  // R2
    {4'd2, 8'h41, 4'd0,  3'd6, 1'b1},  // R2
    {4'd2, 8'h41, 4'd1,  3'd0, 1'b0},  // R2 rotate by one
    {4'd2, 8'h41, 4'd1,  3'd5, 1'b1},  // R2
    {4'd4, 8'h41, 4'd8,  3'd6, 1'b1},  // R4 last glyph row
    {4'd4, 8'h41, 4'd9,  3'd0, 1'b0},  // R4 blank tail
    {4'd5, 8'h67, 4'd0,  3'd0, 1'b0},  // R5 blank top
    {4'd5, 8'h67, 4'd2,  3'd0, 1'b1},  // R5 row 0 at line 2
    {4'd5, 8'h67, 4'd10, 3'd0, 1'b1},  // R5 row 8 at line 10
    {4'd5, 8'h67, 4'd10, 3'd1, 1'b0},  // R5
    {4'd5, 8'h67, 4'd3,  3'd2, 1'b0},  // R5
    {4'd5, 8'h67, 4'd3,  3'd3, 1'b1},  // R5
    {4'd6, 8'h7F, 4'd0,  3'd7, 1'b0},  // R6 pad column
    {4'd6, 8'h7F, 4'd0,  3'd6, 1'b1},  // R6 neighbour lit
    {4'd7, 8'hC1, 4'd0,  3'd0, 1'b0},  // R7
    {4'd8, 8'h7F, 4'd11, 3'd0, 1'b0},  // R8
    {4'd8, 8'h7F, 4'd15, 3'd3, 1'b0},  // R8
    {4'd3, 8'h6A, 4'd1,  3'd0, 1'b0},  // R3
    {4'd3, 8'h6A, 4'd2,  3'd0, 1'b1},  // R3
    {4'd3, 8'h79, 4'd0,  3'd0, 1'b0},  // R3
    {4'd3, 8'h68, 4'd0,  3'd0, 1'b1},  // R3 no flag
    {4'd2, 8'h7F, 4'd8,  3'd3, 1'b1},  // R2
    {4'd2, 8'h00, 4'd4,  3'd3, 1'b0}   // R2
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_code = '0;
  logic [3:0] in_line = '0;
  logic [2:0] in_col = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic       out_pix;

  int  n_checks = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  int  sent, rcvd;
  bit  held;
  logic held_pix;

  always #(CLK_PERIOD/2) clk = ~clk;

  text_char_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_line(in_line), .in_col(in_col),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  function automatic bit model_pix(int code, int line, int col);
    int row, pat;
    bit d;
    if (code > 127 || col > 6) return 1'b0;
    d = (code == 'h67) || (code == 'h6A) || (code == 'h70) || (code == 'h71) || (code == 'h79);
    if (d) begin
      if (line < 2 || line > 10) return 1'b0;
      row = line - 2;
    end else begin
      if (line > 8) return 1'b0;
      row = line;
    end
    pat = code;
    for (int i = 0; i < row % 7; i++) pat = ((pat << 1) | (pat >> 6)) & 'h7F;
    return 1'((pat >> (6 - col)) & 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_item(input bit sweep, input int idx, output logic [7:0] c,
                          output logic [3:0] l, output logic [2:0] k, output bit e,
                          output int req);
    if (sweep) begin
      c = idx[14:7]; l = idx[6:3]; k = idx[2:0];
      e = model_pix(int'(c), int'(l), int'(k));
      req = 2;
    end else begin
      req = int'(VEC[idx][19:16]);
      c = VEC[idx][15:8]; l = VEC[idx][7:4]; k = VEC[idx][3:1]; e = VEC[idx][0];
    end
  endtask

  task automatic step(input bit sweep, input int n, input bit want, input bit rdy);
    logic [7:0] c; logic [3:0] l; logic [2:0] k; bit e; int req;
    @(negedge clk);
    in_valid = want && (sent < n);
    if (in_valid) begin
      get_item(sweep, sent, c, l, k, e, req);
      in_code = c; in_line = l; in_col = k;
    end
    out_ready = rdy;
    #1;
    if (held) check(out_valid && out_pix == held_pix, "R9 stall hold", int'(out_pix), int'(held_pix));
    held = out_valid && !out_ready;
    held_pix = out_pix;
    if (in_valid && in_ready) sent++;
    if (out_valid && out_ready) begin
      get_item(sweep, rcvd, c, l, k, e, req);
      n_checks++;
      if (out_pix !== e) begin
        n_bad++;
        $display("FAIL R%0d/R10 item %0d code=%0h line=%0d col=%0d actual=%0d expected=%0d",
                 req, rcvd, c, l, k, out_pix, e);
      end
      rcvd++;
    end
  endtask

  task automatic run_phase(input bit sweep, input int n);
    int k;
    sent = 0; rcvd = 0; held = 1'b0; k = 0;
    while (rcvd < n && k < 150000) begin
      if (sweep) step(sweep, n, (k % 5) != 3, (k % 3) != 1);
      else       step(sweep, n, 1'b1, 1'b1);
      k++;
    end
    check(rcvd == n && sent == n, "R10 beat count", rcvd, n);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    // R11 during reset
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R11 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R11 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 after reset", int'(out_valid), 0);

    // Table of vectors, full throughput (R2..R8)
    run_phase(1'b0, NV);

    // R1 latency
    repeat (3) @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_code = 8'h41; in_line = 4'd0; in_col = 3'd0;
    @(negedge clk); in_valid = 1'b0; #1;
    check(out_valid == 1'b0, "R1 not after first edge", int'(out_valid), 0);
    @(negedge clk); #1;
    check(out_valid == 1'b1 && out_pix == 1'b1, "R1 after second edge", int'(out_valid), 1);
    @(negedge clk); #1;

    // R10 back-pressure and ordering
    out_ready = 1'b0; in_valid = 1'b1; in_code = 8'h41; in_line = 4'd0; in_col = 3'd0; #1;
    check(in_ready == 1'b1, "R10 accept A", int'(in_ready), 1);
    @(negedge clk); in_col = 3'd1; #1;
    check(in_ready == 1'b1, "R10 accept B", int'(in_ready), 1);
    @(negedge clk); in_code = 8'h7F; in_col = 3'd6; #1;
    check(in_ready == 1'b0, "R10 full stall", int'(in_ready), 0);
    check(out_valid == 1'b1 && out_pix == 1'b1, "R10 head is A", int'(out_pix), 1);
    @(negedge clk); #1;
    check(out_valid == 1'b1 && out_pix == 1'b1 && in_ready == 1'b0, "R9 stalled hold", int'(out_pix), 1);
    out_ready = 1'b1; #1;
    check(in_ready == 1'b1, "R10 ready on drain", int'(in_ready), 1);
    @(negedge clk); in_valid = 1'b0; #1;
    check(out_valid == 1'b1 && out_pix == 1'b0, "R10 second is B", int'(out_pix), 0);
    @(negedge clk); #1;
    check(out_valid == 1'b1 && out_pix == 1'b1, "R10 third is C", int'(out_pix), 1);
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R10 drained", int'(out_valid), 0);

    // Full sweep with gaps and stalls
    run_phase(1'b1, N_SWEEP);

    // R11 reset mid-stream
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_code = 8'h7F; in_line = 4'd0; in_col = 3'd0;
    repeat (3) @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0; #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R11 reset mid-stream", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule